// File: doc/BRIEF.md
# DMA Controller Command, Mask and Status Registers

This block holds the controller-wide registers of a four-channel DMA engine. It decodes a 4-bit port offset. Only the upper half of the range, offsets 8 through 15, has any effect; accesses below offset 8 are handled elsewhere and do nothing here.

Through those eight offsets software can:
- set the command word;
- program a per-channel mode byte;
- manipulate the channel mask, one bit at a time or all at once;
- raise or drop software requests;
- pulse the byte-pointer clear;
- issue a master clear.

The status byte has two nibbles:
- The upper nibble is the live request vector. Software sets it through the request register, and external hold and release strobes change it.
- The lower nibble is the terminal-count flags. A per-channel input from the transfer engine sets them. They are cleared by reading status, by a request write, and by a master clear.

The block drives the mask, the request vector, all four mode bytes and the command word straight to the channel logic. It also drives a one-cycle flip-flop clear pulse for the address/count byte sequencer. The block has no sequencing state machine. One combinational decoder turns each access into an operation code, and a register updates on the following clock edge.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write to offset 8 stores the data as the command only when the data is 8'h00 or 8'h04. Any other value leaves the command unchanged. The command is visible on `cmd_value`.
- R2: A write to offset 9 selects the channel with data[1:0]. It sets the request bit of that channel when data[2]=1 and clears it when data[2]=0. In both cases it clears that channel's terminal-count flag.
- R3: A write to offset 10 sets mask bit data[1:0] when data[2]=1 and clears it when data[2]=0. The other mask bits are not changed.
- R4: A write to offset 11 stores the whole byte into the mode of channel data[1:0]. Channel n's mode appears on `mode_all[8n+7:8n]`.
- R5: A write to offset 12 or 13 makes `ff_clr` high for exactly the one cycle after the write cycle. No other access raises it.
- R6: A write to offset 14 clears all mask bits. A write to offset 15 loads the mask from data[3:0].
- R7: A read registers its result on `rd_data` for the cycle after `rd_en`. The result depends on the offset:
  - Offset 8 returns the status byte {request[3:0], terminal-count[3:0]} and clears the terminal-count flags.
  - Offset 15 returns {4'b0, mask}.
  - Every other offset, and every cycle without a read, gives 0.
- R8: A hold strobe on channel n sets request bit n. A release strobe clears it. When both arrive together, hold wins.
- R9: The external strobes win over register writes and status-read clears in the same cycle:
  - A hold or release strobe wins over a request write or master clear acting on the same request bit.
  - A terminal-count strobe wins over any clear of its flag.
- R10: A write to offset 13 sets all mask bits and clears the command, the request bits and the terminal-count flags. It leaves the mode bytes unchanged.
- R11: Reset applies the same values as the master clear. It also sets every mode byte to 0 and sets `rd_data` and `ff_clr` to 0.
- R12: A pulse on `tc_set[n]` sets terminal-count flag n. The flag stays set until one of the clears in R2, R7 or R10 acts on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 4 | Port offset; only 8..15 act here |
| wr_data | input | 8 | Write data |
| hold_req | input | 4 | Per-channel external request raise strobes |
| rel_req | input | 4 | Per-channel external request drop strobes |
| tc_set | input | 4 | Per-channel terminal-count strobes from the transfer engine |
| rd_data | output | 8 | Registered read data |
| chan_mask | output | 4 | Channel mask, 1 = masked |
| chan_req | output | 4 | Request vector (status upper nibble) |
| mode_all | output | 32 | Four mode bytes, channel n at bits 8n+7:8n |
| cmd_value | output | 8 | Command word |
| ff_clr | output | 1 | One-cycle byte flip-flop clear pulse |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which the access or strobe is presented. This covers the register outputs, `rd_data`, the status-read clear and the `ff_clr` pulse. The bench applies each stimulus for one full cycle, starting at a falling edge. It samples at the next falling edge, when the single register stage has just updated. For `ff_clr` it samples one falling edge later as well, to confirm the pulse lasts one cycle. Terminal-count flags have no output port, so the bench reads them through the status read. It then reads status a second time to check that the first read cleared them.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int NCH  = 4;              // channels per controller
    localparam int DW   = 8;              // data bus width
    localparam int AW   = 4;              // port offset width
    localparam int CSW  = $clog2(NCH);    // channel-select width
    localparam int SETB = CSW;            // set/clear select bit in data
    localparam int MW   = NCH * DW;       // packed mode width

    // only this bit may be set in an accepted command word
    localparam logic [DW-1:0] CMD_ALLOWED = 8'h04;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CMD,
        OP_REQ,
        OP_SMASK,
        OP_MODE,
        OP_FFCLR,
        OP_MCLR,
        OP_UNMASK_ALL,
        OP_MASK_LOAD
    } wr_op_e;

    typedef enum logic [1:0] {
        RSEL_ZERO,
        RSEL_STATUS,
        RSEL_MASK
    } rd_sel_e;

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
    import dma_ctl_pkg::*;
(
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    output wr_op_e        wr_op,
    output rd_sel_e       rd_sel
);

    localparam logic [AW-2:0] SUB_CMD   = 3'd0;
    localparam logic [AW-2:0] SUB_REQ   = 3'd1;
    localparam logic [AW-2:0] SUB_SMASK = 3'd2;
    localparam logic [AW-2:0] SUB_MODE  = 3'd3;
    localparam logic [AW-2:0] SUB_FFCLR = 3'd4;
    localparam logic [AW-2:0] SUB_MCLR  = 3'd5;
    localparam logic [AW-2:0] SUB_UNMSK = 3'd6;
    localparam logic [AW-2:0] SUB_MLOAD = 3'd7;

    logic          upper;
    logic [AW-2:0] sub;

    assign upper = addr[AW-1];
    assign sub   = addr[AW-2:0];

    always_comb begin
        wr_op = OP_NONE;
        if (wr_en && upper) begin
            unique case (sub)
                SUB_CMD:   wr_op = OP_CMD;
                SUB_REQ:   wr_op = OP_REQ;
                SUB_SMASK: wr_op = OP_SMASK;
                SUB_MODE:  wr_op = OP_MODE;
                SUB_FFCLR: wr_op = OP_FFCLR;
                SUB_MCLR:  wr_op = OP_MCLR;
                SUB_UNMSK: wr_op = OP_UNMASK_ALL;
                SUB_MLOAD: wr_op = OP_MASK_LOAD;
                default:   wr_op = OP_NONE;
            endcase
        end
    end

    always_comb begin
        rd_sel = RSEL_ZERO;
        if (rd_en && upper) begin
            if (sub == SUB_CMD)
                rd_sel = RSEL_STATUS;
            else if (sub == SUB_MLOAD)
                rd_sel = RSEL_MASK;
        end
    end

endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status
    import dma_ctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  wr_op_e         wr_op,
    input  logic [DW-1:0]  wr_data,
    input  logic           rd_status,
    input  logic [NCH-1:0] hold_req,
    input  logic [NCH-1:0] rel_req,
    input  logic [NCH-1:0] tc_set,
    output logic [NCH-1:0] req_q,
    output logic [NCH-1:0] tc_q
);

    logic [NCH-1:0] req_n;
    logic [NCH-1:0] tc_n;
    logic [CSW-1:0] sel;

    assign sel = wr_data[CSW-1:0];

    always_comb begin
        req_n = req_q;
        tc_n  = tc_q;
        // register-side updates first
        if (wr_op == OP_MCLR) begin
            req_n = '0;
            tc_n  = '0;
        end
        if (wr_op == OP_REQ) begin
            req_n[sel] = wr_data[SETB];
            tc_n[sel]  = 1'b0;
        end
        if (rd_status)
            tc_n = '0;
        // external strobes override
        for (int i = 0; i < NCH; i++) begin
            if (hold_req[i])
                req_n[i] = 1'b1;
            else if (rel_req[i])
                req_n[i] = 1'b0;
            if (tc_set[i])
                tc_n[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            tc_q  <= '0;
        end else begin
            req_q <= req_n;
            tc_q  <= tc_n;
        end
    end

endmodule

// File: rtl/dma_ctl_mask.sv
module dma_ctl_mask
    import dma_ctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  wr_op_e         wr_op,
    input  logic [DW-1:0]  wr_data,
    output logic [NCH-1:0] mask_q
);

    logic [NCH-1:0] mask_n;
    logic [CSW-1:0] sel;

    assign sel = wr_data[CSW-1:0];

    always_comb begin
        mask_n = mask_q;
        unique case (wr_op)
            OP_SMASK:      mask_n[sel] = wr_data[SETB];
            OP_MCLR:       mask_n      = '1;
            OP_UNMASK_ALL: mask_n      = '0;
            OP_MASK_LOAD:  mask_n      = wr_data[NCH-1:0];
            default:       mask_n      = mask_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else
            mask_q <= mask_n;
    end

endmodule

// File: rtl/dma_ctl_modes.sv
module dma_ctl_modes
    import dma_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  wr_op_e        wr_op,
    input  logic [DW-1:0] wr_data,
    output logic [MW-1:0] mode_all
);

    logic [CSW-1:0] sel;
    assign sel = wr_data[CSW-1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [DW-1:0] mode_q;

        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q <= '0;
            else if (wr_op == OP_MODE && sel == CSW'(g))
                mode_q <= wr_data;
        end

        assign mode_all[g*DW +: DW] = mode_q;
    end

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [NCH-1:0] hold_req,
    input  logic [NCH-1:0] rel_req,
    input  logic [NCH-1:0] tc_set,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] chan_mask,
    output logic [NCH-1:0] chan_req,
    output logic [MW-1:0]  mode_all,
    output logic [DW-1:0]  cmd_value,
    output logic           ff_clr
);

    wr_op_e         wr_op;
    rd_sel_e        rd_sel;
    logic [NCH-1:0] tc_q;
    logic           cmd_ok;
    logic [DW-1:0]  rd_n;

    dma_ctl_decode u_decode (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wr_op  (wr_op),
        .rd_sel (rd_sel)
    );

    dma_ctl_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_op     (wr_op),
        .wr_data   (wr_data),
        .rd_status (rd_sel == RSEL_STATUS),
        .hold_req  (hold_req),
        .rel_req   (rel_req),
        .tc_set    (tc_set),
        .req_q     (chan_req),
        .tc_q      (tc_q)
    );

    dma_ctl_mask u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_op   (wr_op),
        .wr_data (wr_data),
        .mask_q  (chan_mask)
    );

    dma_ctl_modes u_modes (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_op    (wr_op),
        .wr_data  (wr_data),
        .mode_all (mode_all)
    );

    // command accepted only if no bit outside the allowed set is high
    assign cmd_ok = (wr_data & ~CMD_ALLOWED) == '0;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_value <= '0;
        else if (wr_op == OP_MCLR)
            cmd_value <= '0;
        else if (wr_op == OP_CMD && cmd_ok)
            cmd_value <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ff_clr <= 1'b0;
        else
            ff_clr <= (wr_op == OP_FFCLR) || (wr_op == OP_MCLR);
    end

    always_comb begin
        unique case (rd_sel)
            RSEL_STATUS: rd_n = {chan_req, tc_q};
            RSEL_MASK:   rd_n = DW'(chan_mask);
            default:     rd_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else
            rd_data <= rd_n;
    end

endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk
    import dma_ctl_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           rd_en,
    input logic [AW-1:0]  addr,
    input logic [DW-1:0]  wr_data,
    input logic [NCH-1:0] hold_req,
    input logic [NCH-1:0] rel_req,
    input logic [NCH-1:0] tc_set,
    input logic [DW-1:0]  rd_data,
    input logic [NCH-1:0] chan_mask,
    input logic [NCH-1:0] chan_req,
    input logic [MW-1:0]  mode_all,
    input logic [DW-1:0]  cmd_value,
    input logic           ff_clr
);

    p_cmd_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd8 && (wr_data & ~CMD_ALLOWED) != '0) |=> $stable(cmd_value));

    p_ffclr_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ff_clr |-> $past(wr_en && (addr == 4'd12 || addr == 4'd13)));

    p_unmask_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd14) |=> (chan_mask == '0));

    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd15) |=> (chan_mask == $past(wr_data[NCH-1:0])));

    p_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || (addr != 4'd8 && addr != 4'd15)) |=> (rd_data == '0));

    p_hold_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req != '0) |=> ((chan_req & $past(hold_req)) == $past(hold_req)));

    p_release_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rel_req & ~hold_req) != '0) |=> ((chan_req & $past(rel_req & ~hold_req)) == '0));

    p_master_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd13) |=> (chan_mask == '1 && cmd_value == '0));

endmodule

bind dma_ctl_regs dma_ctl_regs_chk u_chk (.*);

// File: tb/dma_ctl_regs_test.sv
module dma_ctl_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  hold_req = '0;
    logic [3:0]  rel_req = '0;
    logic [3:0]  tc_set = '0;
    logic [7:0]  rd_data;
    logic [3:0]  chan_mask;
    logic [3:0]  chan_req;
    logic [31:0] mode_all;
    logic [7:0]  cmd_value;
    logic        ff_clr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_cmd;
    logic [3:0] m_mask, m_req, m_tc;
    logic [7:0] m_mode [4];

    always #5 clk = ~clk;

    dma_ctl_regs uut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic [3:0] a,
                        input logic [7:0] d, input logic [3:0] h,
                        input logic [3:0] rl, input logic [3:0] t);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wr_data = d;
        hold_req = h; rel_req = rl; tc_set = t;
        @(negedge clk);
        wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
        hold_req = '0; rel_req = '0; tc_set = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        step(1'b1, 1'b0, a, d, 4'h0, 4'h0, 4'h0);
    endtask

    task automatic rd(input logic [3:0] a);
        step(1'b0, 1'b1, a, 8'h00, 4'h0, 4'h0, 4'h0);
    endtask

    function automatic logic [31:0] pack_modes();
        return {m_mode[3], m_mode[2], m_mode[1], m_mode[0]};
    endfunction

    task automatic model_clear();
        m_cmd = 0; m_mask = 4'hF; m_req = 0; m_tc = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        for (int c = 0; c < 4; c++) m_mode[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11 mask", chan_mask, 4'hF);
        chk("R11 req", chan_req, 0);
        chk("R11 cmd", cmd_value, 0);
        chk("R11 modes", mode_all, 0);
        chk("R11 ff_clr", ff_clr, 0);
        chk("R11 rd_data", rd_data, 0);

        // R1: full command sweep
        for (int v = 0; v < 256; v++) begin
            wr(4'd8, 8'(v));
            if (v == 0 || v == 4) m_cmd = 8'(v);
            chk("R1 cmd", cmd_value, m_cmd);
        end

        // R4: mode per channel
        for (int c = 0; c < 4; c++) begin
            logic [7:0] d;
            d = 8'((c * 8'h4C + 8'h94) & 8'hFC) | 8'(c);
            wr(4'd11, d);
            m_mode[c] = d;
            chk("R4 modes", mode_all, pack_modes());
        end

        // R6: load then R3 single mask sweep
        wr(4'd15, 8'hA5);
        m_mask = 4'h5;
        chk("R6 load", chan_mask, m_mask);
        for (int v = 0; v < 16; v++) begin
            wr(4'd10, 8'(v) | 8'hF0);
            m_mask[v[1:0]] = v[2];
            chk("R3 single mask", chan_mask, m_mask);
        end
        for (int v = 0; v < 16; v++) begin
            wr(4'd15, 8'(v) | 8'h60);
            m_mask = 4'(v);
            chk("R6 load sweep", chan_mask, m_mask);
        end
        wr(4'd14, 8'hFF);
        m_mask = 0;
        chk("R6 clear all", chan_mask, 0);

        // R2, R12, R7: request writes with terminal counts preset
        for (int v = 0; v < 8; v++) begin
            step(1'b0, 1'b0, 4'd0, 8'h00, 4'h0, 4'h0, 4'hF);
            m_tc = 4'hF;
            wr(4'd9, 8'(v));
            m_req[v[1:0]] = v[2];
            m_tc[v[1:0]] = 1'b0;
            chk("R2 req", chan_req, m_req);
            rd(4'd8);
            chk("R7 R12 status", rd_data, {m_req, m_tc});
            m_tc = 0;
            rd(4'd8);
            chk("R7 status clears tc", rd_data, {m_req, 4'h0});
        end

        // R7: other offsets read 0, offset 15 reads mask
        wr(4'd15, 8'h09);
        m_mask = 4'h9;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a));
            if (a == 15)      chk("R7 mask read", rd_data, {4'h0, m_mask});
            else if (a == 8)  chk("R7 status read", rd_data, {m_req, m_tc});
            else              chk("R7 zero read", rd_data, 0);
        end

        // R8: hold and release strobes
        wr(4'd9, 8'h00); wr(4'd9, 8'h01); wr(4'd9, 8'h02); wr(4'd9, 8'h03);
        m_req = 0;
        for (int c = 0; c < 4; c++) begin
            step(1'b0, 1'b0, 4'd0, 8'h00, 4'(1 << c), 4'h0, 4'h0);
            m_req[c] = 1'b1;
            chk("R8 hold", chan_req, m_req);
        end
        step(1'b0, 1'b0, 4'd0, 8'h00, 4'h0, 4'h5, 4'h0);
        m_req = 4'hA;
        chk("R8 release", chan_req, m_req);
        step(1'b0, 1'b0, 4'd0, 8'h00, 4'h1, 4'h3, 4'h0);
        m_req = 4'h9;
        chk("R8 hold beats release", chan_req, m_req);

        // R9: strobes win over register side
        step(1'b1, 1'b0, 4'd9, 8'h00, 4'h1, 4'h0, 4'h0);
        chk("R9 hold vs req write", chan_req, m_req);
        step(1'b1, 1'b0, 4'd9, 8'h07, 4'h0, 4'h8, 4'h0);
        m_req = 4'h1;
        chk("R9 release vs req write", chan_req, m_req);
        step(1'b0, 1'b0, 4'd0, 8'h00, 4'h0, 4'h0, 4'h6);
        m_tc = 4'h6;
        step(1'b0, 1'b1, 4'd8, 8'h00, 4'h0, 4'h0, 4'h2);
        chk("R9 status read old value", rd_data, {m_req, m_tc});
        m_tc = 4'h2;
        rd(4'd8);
        chk("R9 tc strobe beats read clear", rd_data, {m_req, m_tc});
        m_tc = 0;

        // R5: flip-flop clear pulse
        @(negedge clk);
        wr_en = 1; addr = 4'd12; wr_data = 8'h5A;
        @(negedge clk);
        wr_en = 0; addr = 0; wr_data = 0;
        chk("R5 pulse high", ff_clr, 1);
        @(negedge clk);
        chk("R5 pulse one cycle", ff_clr, 0);
        wr(4'd11, 8'h00);
        m_mode[0] = 0;
        chk("R5 no pulse on mode write", ff_clr, 0);

        // R10: master clear
        wr(4'd8, 8'h04); wr(4'd15, 8'h02);
        step(1'b0, 1'b0, 4'd0, 8'h00, 4'h6, 4'h0, 4'h9);
        m_cmd = 8'h04; m_mask = 4'h2; m_req = 4'h7; m_tc = 4'h9;
        chk("R10 pre cmd", cmd_value, m_cmd);
        @(negedge clk);
        wr_en = 1; addr = 4'd13; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 0; addr = 0; wr_data = 0;
        model_clear();
        chk("R10 R5 pulse", ff_clr, 1);
        chk("R10 mask", chan_mask, 4'hF);
        chk("R10 cmd", cmd_value, 0);
        chk("R10 req", chan_req, 0);
        chk("R10 modes kept", mode_all, pack_modes());
        rd(4'd8);
        chk("R10 status", rd_data, 0);

        // R11: reset mid-run
        wr(4'd14, 8'h00); wr(4'd8, 8'h04);
        step(1'b0, 1'b0, 4'd0, 8'h00, 4'hC, 4'h0, 4'h3);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        for (int c = 0; c < 4; c++) m_mode[c] = 0;
        model_clear();
        chk("R11 mask", chan_mask, m_mask);
        chk("R11 cmd", cmd_value, 0);
        chk("R11 req", chan_req, 0);
        chk("R11 modes", mode_all, 0);
        rd(4'd8);
        chk("R11 status", rd_data, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule